// File: doc/BRIEF.md
# Fairness-Interval Bus Arbiter

This block decides which of several nodes on a shared serial bus may transmit next. Each node presents a request line together with static settings: its distance from the root of the bus tree, a node identifier, and an urgent flag. When several nodes compete, the one closest to the root wins, then the one with the smaller identifier. The winner receives a one-hot grant that it keeps until its packet has finished, as seen on the bus-busy input.

Fairness is enforced through intervals. A node that wins within an interval is locked out until that interval closes. The interval closes when no node that is still allowed to compete is requesting, and at that point every lockout is cleared. Urgent nodes are exempt from the lockout and rank ahead of all non-urgent contenders. Among themselves they use the same depth-then-identifier order. After every packet, the arbiter waits a programmable number of idle clocks before it issues the next grant, so that the acknowledge exchange is not disturbed.

The controller has four states. ST_GAP counts idle clocks after a packet. ST_IDLE arbitrates. ST_GRANT holds a grant while it waits for the bus to go busy. ST_XFER holds the grant until the bus goes idle again. The transitions are as follows. ST_GAP moves to ST_IDLE when the count reaches the programmed gap. ST_IDLE moves to ST_GRANT when an eligible request exists. ST_IDLE stays in ST_IDLE and clears all lockouts when there is none. ST_IDLE returns to ST_GAP if the bus goes busy. ST_GRANT moves to ST_XFER when the bus goes busy. ST_XFER moves to ST_GAP when the bus goes idle.

Top module: `fair_bus_arbiter`

## Requirements
- R1: While reset is asserted and after it is released with no request, grant is all zeros.
- R2: At most one grant bit is ever set.
- R3: Among contenders of the same urgency class, a node with a smaller depth value wins over any node with a larger depth value.
- R4: Among contenders of equal depth and urgency class, the node with the smaller identifier wins.
- R5: When depth and identifier are both equal, the node with the lower bit index in the request vector wins.
- R6: A non-urgent node that has already won within the current interval is not granted again while another eligible node is requesting.
- R7: When no eligible node requests, all lockouts are cleared. A node that won earlier can then win again, and the interval restarts with normal priority.
- R8: An urgent requester beats every non-urgent requester and is never locked out. Among urgent requesters the depth-then-identifier order applies.
- R9: Once issued, a grant stays unchanged, even if the request drops, until bus_busy has been seen high and then low. It clears on the clock edge that samples bus_busy low in ST_XFER.
- R10: With requests waiting and bus_busy staying low, grant stays zero for exactly gap_len+2 clock cycles between two packets. A bus_busy pulse during the gap restarts the idle count and lengthens the gap.
- R11: A grant is only given to a node whose request was high in the cycle before the grant appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NODES | Per-node request lines |
| urgent | input | NODES | Per-node urgent class setting |
| node_depth | input | NODES*DEPTH_W | Packed per-node tree depth, node i at bits [i*DEPTH_W +: DEPTH_W] |
| node_id | input | NODES*ID_W | Packed per-node identifier, node i at bits [i*ID_W +: ID_W] |
| gap_len | input | GAP_W | Number of idle clocks required after a packet |
| bus_busy | input | 1 | High while a packet occupies the bus |
| grant | output | NODES | One-hot grant, zero when no node holds the bus |

## Verification
The ordering tests put pairs of requesters side by side. In one pair only the depth differs, in another only the identifier, and in a third neither differs. Each of these cases can only pass through its own ordering rule. Two requesters that never release their requests show the lockout as a strict alternation, and a third grant that returns to the first winner shows that the interval closed and cleared the lockouts. Adding urgent nodes to a continuously requesting non-urgent node shows repeated wins with no alternation, and a second urgent node shows that depth still orders the urgent class. Gap timing is measured between back-to-back packets, once with a quiet bus and once with a stray busy pulse, which separates a fixed delay from an idle-count restart.

// File: rtl/fab_pkg.sv
package fab_pkg;

    typedef enum logic [1:0] {
        ST_GAP   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_GRANT = 2'd2,
        ST_XFER  = 2'd3
    } fab_state_e;

endpackage

// File: rtl/fab_pick.sv
module fab_pick #(
    parameter int NODES   = 8,
    parameter int DEPTH_W = 4,
    parameter int ID_W    = 6
) (
    input  logic [NODES-1:0]         cand,
    input  logic [NODES-1:0]         urgent,
    input  logic [NODES*DEPTH_W-1:0] node_depth,
    input  logic [NODES*ID_W-1:0]    node_id,
    output logic [NODES-1:0]         win,
    output logic                     any
);
    localparam int KEY_W = 1 + DEPTH_W + ID_W;
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

    logic [KEY_W-1:0] key [NODES];

    // rank key: non-urgent flag first, then depth, then identifier (smaller is better)
    generate
        for (genvar g = 0; g < NODES; g++) begin : g_key
            assign key[g] = {~urgent[g],
                             node_depth[g*DEPTH_W +: DEPTH_W],
                             node_id[g*ID_W +: ID_W]};
        end
    endgenerate

    logic [KEY_W-1:0] best_key;
    logic [IDX_W-1:0] best_idx;
    logic             found;

    always_comb begin
        best_key = '1;
        best_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < NODES; i++) begin
            // strict compare keeps the lower index on a full tie
            if (cand[i] && (!found || key[i] < best_key)) begin
                best_key = key[i];
                best_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        win = '0;
        if (found) begin
            win[best_idx] = 1'b1;
        end
    end

    assign any = found;

endmodule

// File: rtl/fab_gap_timer.sv
module fab_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             bus_busy,
    input  logic [GAP_W-1:0] gap_len,
    output logic             done
);
    logic [GAP_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || restart || bus_busy) begin
            idle_cnt <= '0;
        end else if (idle_cnt != gap_len) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign done = !restart && !bus_busy && (idle_cnt == gap_len);

    // R10: a busy bus always holds the count at zero on the next cycle
    p_busy_resets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |=> (idle_cnt == '0));

endmodule

// File: rtl/fab_won_track.sv
module fab_won_track #(
    parameter int NODES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [NODES-1:0] set_vec,
    input  logic             clear_all,
    output logic [NODES-1:0] won
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            won <= '0;
        end else if (set_en) begin
            won <= won | set_vec;
        end
    end

    // R7: a clear request empties every lockout on the next cycle
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> (won == '0));

endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter
    import fab_pkg::*;
#(
    parameter int NODES   = 8,
    parameter int DEPTH_W = 4,
    parameter int ID_W    = 6,
    parameter int GAP_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NODES-1:0]         req,
    input  logic [NODES-1:0]         urgent,
    input  logic [NODES*DEPTH_W-1:0] node_depth,
    input  logic [NODES*ID_W-1:0]    node_id,
    input  logic [GAP_W-1:0]         gap_len,
    input  logic                     bus_busy,
    output logic [NODES-1:0]         grant
);
    fab_state_e       state_q, state_d;
    logic [NODES-1:0] won_q;
    logic [NODES-1:0] eligible;
    logic [NODES-1:0] pick_vec;
    logic             pick_any;
    logic             gap_done;
    logic             gap_restart;
    logic             do_grant;
    logic             do_release;
    logic             close_interval;
    logic [NODES-1:0] grant_q;

    // urgent nodes bypass the lockout
    assign eligible = req & (~won_q | urgent);

    fab_pick #(
        .NODES   (NODES),
        .DEPTH_W (DEPTH_W),
        .ID_W    (ID_W)
    ) u_pick (
        .cand       (eligible),
        .urgent     (urgent),
        .node_depth (node_depth),
        .node_id    (node_id),
        .win        (pick_vec),
        .any        (pick_any)
    );

    assign gap_restart = (state_q != ST_GAP);

    fab_gap_timer #(
        .GAP_W (GAP_W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (gap_restart),
        .bus_busy (bus_busy),
        .gap_len  (gap_len),
        .done     (gap_done)
    );

    assign do_grant       = (state_q == ST_IDLE) && !bus_busy && pick_any;
    assign close_interval = (state_q == ST_IDLE) && !bus_busy && !pick_any;
    assign do_release     = (state_q == ST_XFER) && !bus_busy;

    fab_won_track #(
        .NODES (NODES)
    ) u_won (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (do_grant),
        .set_vec   (pick_vec),
        .clear_all (close_interval),
        .won       (won_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GAP;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GAP: begin
                if (gap_done) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (bus_busy)      state_d = ST_GAP;
                else if (pick_any) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                if (bus_busy) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (!bus_busy) state_d = ST_GAP;
            end
            default: state_d = ST_GAP;
        endcase
    end

    // grant output register
    always_ff @(posedge clk) begin
        if (!rst_n || do_release) begin
            grant_q <= '0;
        end else if (do_grant) begin
            grant_q <= pick_vec;
        end
    end

    assign grant = grant_q;

    // R2: never more than one grant bit
    p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9: a granted node keeps the bus while waiting for the packet to start
    p_hold_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT) |=> (grant == $past(grant)));

    // R11: a new grant goes only to a node that was requesting
    p_grant_to_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && ($past(grant) == '0)) |-> ((grant & ~$past(req)) == '0));

    // R6: a new grant never goes to a locked-out non-urgent node
    p_no_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && ($past(grant) == '0))
            |-> ((grant & $past(won_q) & ~$past(urgent)) == '0));

    // R10: a grant only starts after an idle bus cycle
    p_grant_after_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != '0) && ($past(grant) == '0)) |-> !$past(bus_busy));

endmodule

// File: tb/tb_fair_bus_arbiter.sv
`timescale 1ns/1ps
module tb_fair_bus_arbiter;
    localparam int NODES   = 8;
    localparam int DEPTH_W = 4;
    localparam int ID_W    = 6;
    localparam int GAP_W   = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NODES-1:0]         req = '0;
    logic [NODES-1:0]         urgent = '0;
    logic [NODES*DEPTH_W-1:0] node_depth = '0;
    logic [NODES*ID_W-1:0]    node_id = '0;
    logic [GAP_W-1:0]         gap_len = 8'd2;
    logic                     bus_busy = 1'b0;
    logic [NODES-1:0]         grant;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fair_bus_arbiter #(
        .NODES(NODES), .DEPTH_W(DEPTH_W), .ID_W(ID_W), .GAP_W(GAP_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .urgent(urgent),
        .node_depth(node_depth), .node_id(node_id), .gap_len(gap_len),
        .bus_busy(bus_busy), .grant(grant)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic set_node(input int i, input int d, input int id);
        node_depth[i*DEPTH_W +: DEPTH_W] = DEPTH_W'(d);
        node_id[i*ID_W +: ID_W]          = ID_W'(id);
    endtask

    function automatic int idx_of(input logic [NODES-1:0] v);
        for (int i = 0; i < NODES; i++) if (v[i]) return i;
        return -1;
    endfunction

    // waits for a grant, checks R2/R11, runs a short packet, returns winner
    task automatic transfer(output int idx);
        int waited = 0;
        logic [NODES-1:0] req_seen;
        idx = -1;
        while (grant == '0 && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        if (grant == '0) begin
            check("R11 grant timeout", 0, 1);
            return;
        end
        req_seen = req;
        check("R2 single grant bit", $countones(grant), 1);
        check("R11 granted node requested", int'((grant & ~req_seen) == '0), 1);
        idx = idx_of(grant);
        bus_busy = 1'b1;
        repeat (3) @(negedge clk);
        bus_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        req = '0;
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        req = 8'h21;
        repeat (4) @(negedge clk);
        check("R1 grant zero in reset", int'(grant), 0);
        req = '0;
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 grant zero without requests", int'(grant), 0);
    endtask

    task automatic t_depth();
        int w;
        req = 8'b0010_0100;          // node 2 depth 3, node 5 depth 1
        transfer(w);
        check("R3 nearer root wins", w, 5);
        settle();
    endtask

    task automatic t_ident();
        int w;
        req = 8'b0100_0010;          // nodes 1 and 6 both depth 2, ids 7 and 3
        transfer(w);
        check("R4 lower id wins", w, 6);
        settle();
    endtask

    task automatic t_index_tie();
        int w;
        req = 8'b0001_1000;          // nodes 3 and 4 identical settings
        transfer(w);
        check("R5 lower index on full tie", w, 3);
        settle();
    endtask

    task automatic t_fairness();
        int w;
        req = 8'b0000_0101;          // nodes 0 (id 10) and 2 (id 1), depth 3
        transfer(w);
        check("R4 first winner by id", w, 2);
        transfer(w);
        check("R6 locked-out node skipped", w, 0);
        transfer(w);
        check("R7 new interval restarts order", w, 2);
        transfer(w);
        check("R6 second round alternates", w, 0);
        settle();
    endtask

    task automatic t_urgent();
        int w;
        urgent = 8'b1000_0000;       // node 7 urgent, depth 5
        req    = 8'b1010_0000;       // with node 5 depth 1 non-urgent
        for (int k = 0; k < 3; k++) begin
            transfer(w);
            check("R8 urgent wins repeatedly", w, 7);
        end
        settle();
        urgent = 8'b1100_0000;       // node 6 urgent depth 2
        req    = 8'b1110_0000;
        transfer(w);
        check("R8 urgent ordered by depth", w, 6);
        transfer(w);
        check("R8 urgent not locked out", w, 6);
        settle();
        urgent = '0;
    endtask

    task automatic t_hold();
        logic [NODES-1:0] g;
        req = 8'b0000_0010;
        while (grant == '0) @(negedge clk);
        g = grant;
        req = '0;
        repeat (5) @(negedge clk);
        check("R9 grant held after request drop", int'(grant), int'(g));
        bus_busy = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 grant held while busy", int'(grant), int'(g));
        bus_busy = 1'b0;
        @(negedge clk);
        check("R9 grant cleared after busy falls", int'(grant), 0);
        settle();
    endtask

    task automatic t_gap();
        int zeros;
        gap_len = 8'd5;
        req = 8'b0000_0101;
        while (grant == '0) @(negedge clk);
        bus_busy = 1'b1;
        repeat (2) @(negedge clk);
        bus_busy = 1'b0;
        zeros = 0;
        @(negedge clk);
        while (grant == '0 && zeros < 100) begin
            zeros++;
            @(negedge clk);
        end
        check("R10 quiet gap length", zeros, 7);
        bus_busy = 1'b1;
        repeat (2) @(negedge clk);
        bus_busy = 1'b0;
        zeros = 0;
        @(negedge clk);
        while (grant == '0 && zeros < 100) begin
            zeros++;
            if (zeros == 3) bus_busy = 1'b1;
            else bus_busy = 1'b0;
            @(negedge clk);
        end
        bus_busy = 1'b0;
        check("R10 busy pulse lengthens gap", int'(zeros > 7), 1);
        bus_busy = 1'b1;
        repeat (2) @(negedge clk);
        bus_busy = 1'b0;
        settle();
        gap_len = 8'd2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        set_node(0, 3, 10);
        set_node(1, 2, 7);
        set_node(2, 3, 1);
        set_node(3, 4, 12);
        set_node(4, 4, 12);
        set_node(5, 1, 9);
        set_node(6, 2, 3);
        set_node(7, 5, 20);
        @(negedge clk);
        t_reset();
        t_depth();
        t_ident();
        t_index_tie();
        t_fairness();
        t_urgent();
        t_hold();
        t_gap();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule